// File: doc/BRIEF.md
# Event Aggregator with Pending and Enable Registers

This block gathers a parameterised number of single-bit event lines into one combined event output. Each line passes through its own trigger detector. The detector can fire on level, on a rising edge or on a falling edge, and the mode is fixed per line by a parameter. A detector firing latches a sticky pending bit for that line.

Software reaches the block over a small strobe-based register port with two registers. The enable register masks the pending bits. The pending register is read to find which lines fired, and writing ones to it clears those bits. The combined output is high while any line has both its pending bit and its enable bit set, so a downstream interrupt controller or a parent aggregator can treat it as one more event line.

Top module: `evmon_aggregator`

## Requirements
- R1: A write with address 0 replaces the enable register with the low NUM_SRC bits of the write data. Upper write-data bits are dropped, and a later read of address 0 returns the stored mask.
- R2: After reset, the enable register, the pending register, the read data and the combined output are all 0.
- R3: A detector firing sets that line's pending bit on the next clock edge, which is two edges after the line changes at the port. The bit stays set after the line returns to its idle value, until software clears it.
- R4: A write with address 1 clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: The combined output equals the OR over all lines of (pending AND enable). It is 0 whenever the matching enable bits are 0. When an enable bit is written to 1 over a pending bit that is already set, the output is high right after that write edge.
- R6: A read is a one-cycle read strobe with the address held. The read data is updated at that edge and holds until the next read. Addresses other than 0 and 1 read as 0, and bits above NUM_SRC read as 0.
- R7: Per-line mode codes in SRC_MODES, two bits per line with line i at bits [2i+1:2i], are: 0 = level, 1 = rising edge, 2 = falling edge. Code 3 stops elaboration. A level-mode line fires on every cycle in which its registered input is 1.
- R8: A rising-edge line fires only on a 0-to-1 change of its registered input. Holding the line high or dropping it does not fire it.
- R9: A falling-edge line fires only on a 1-to-0 change of its registered input. Raising the line does not fire it.
- R10: When a line fires in the same cycle that a clear write hits its pending bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Event lines, one per source |
| regAddr | input | ADDR_W | Register address (0 enable, 1 pending) |
| rdStb | input | 1 | One-cycle read strobe |
| wrStb | input | 1 | One-cycle write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| evOut | output | 1 | Combined event output |

## Verification
A change on an event line reaches the pending register two edges later: one edge for the input register and one for the pending latch. The bench therefore waits three falling edges before it reads. A register write takes effect at the single rising edge inside the strobe. The enable readback and the combined output are checked at the falling edge that follows, while read data is sampled at the falling edge after the read strobe's edge. The set-wins case places the clear strobe exactly in the cycle where the detector fires, one edge after the line changes. The mask and clear behaviour is swept over all sixteen enable values and all sixteen clear masks of a four-line configuration.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2
  } trigMode_e;

  localparam int EN_ADDR   = 0;
  localparam int PEND_ADDR = 1;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_EN   = 2'd1,
    RD_PEND = 2'd2
  } rdSel_e;

  // strobes from register decode to datapath
  typedef struct packed {
    logic   enWr;
    logic   pendWr;
    logic   rdEn;
    rdSel_e rdSel;
  } regCtl_t;

endpackage

// File: rtl/evmon_detect.sv
module evmon_detect
  import evmon_pkg::*;
#(
  parameter int                     NUM_SRC   = 4,
  parameter logic [2*NUM_SRC-1:0]   SRC_MODES = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] trigVec
);

  logic [NUM_SRC-1:0] inReg;
  logic [NUM_SRC-1:0] prevReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg   <= '0;
      prevReg <= '0;
    end else begin
      inReg   <= srcIn;
      prevReg <= inReg;
    end
  end

  // elaboration-time check of each line's mode code
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_modeChk
    if (SRC_MODES[2*i +: 2] == 2'd3) begin : g_bad
      $error("evmon_detect: line %0d has an illegal trigger mode code", i);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      case (SRC_MODES[2*i +: 2])
        TRIG_LEVEL: trigVec[i] = inReg[i];
        TRIG_RISE:  trigVec[i] = inReg[i] & ~prevReg[i];
        TRIG_FALL:  trigVec[i] = ~inReg[i] & prevReg[i];
        default:    trigVec[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  output regCtl_t           ctl
);

  logic hitEn;
  logic hitPend;

  assign hitEn   = (regAddr == ADDR_W'(EN_ADDR));
  assign hitPend = (regAddr == ADDR_W'(PEND_ADDR));

  always_comb begin
    ctl.enWr   = wrStb & hitEn;
    ctl.pendWr = wrStb & hitPend;
    ctl.rdEn   = rdStb;
    if (hitEn)        ctl.rdSel = RD_EN;
    else if (hitPend) ctl.rdSel = RD_PEND;
    else              ctl.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/evmon_datapath.sv
module evmon_datapath
  import evmon_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  regCtl_t            ctl,
  input  logic [NUM_SRC-1:0] wrLo,
  input  logic [NUM_SRC-1:0] trigVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [DATA_W-1:0]  rdData,
  output logic               evOut
);

  logic [NUM_SRC-1:0] clrMask;
  logic [DATA_W-1:0]  rdNext;

  assign clrMask = ctl.pendWr ? wrLo : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec <= '0;
    end else if (ctl.enWr) begin
      enVec <= wrLo;
    end
  end

  // a firing detector overrides a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVec <= '0;
    end else begin
      pendVec <= (pendVec & ~clrMask) | trigVec;
    end
  end

  always_comb begin
    rdNext = '0;
    case (ctl.rdSel)
      RD_EN:   rdNext[NUM_SRC-1:0] = enVec;
      RD_PEND: rdNext[NUM_SRC-1:0] = pendVec;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.rdEn) begin
      rdData <= rdNext;
    end
  end

  assign evOut = |(pendVec & enVec);

endmodule

// File: rtl/evmon_aggregator.sv
module evmon_aggregator
  import evmon_pkg::*;
#(
  parameter int                   NUM_SRC   = 4,
  parameter int                   DATA_W    = 8,
  parameter int                   ADDR_W    = 2,
  parameter logic [2*NUM_SRC-1:0] SRC_MODES = 8'h24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               rdStb,
  input  logic               wrStb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               evOut
);

  if (NUM_SRC > DATA_W) begin : g_widthBad
    $error("evmon_aggregator: NUM_SRC must not exceed DATA_W");
  end

  regCtl_t            ctl;
  logic [NUM_SRC-1:0] trigVec;
  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] pendVec;
  logic               unusedWrHi;

  assign unusedWrHi = ^wrData;

  evmon_detect #(
    .NUM_SRC  (NUM_SRC),
    .SRC_MODES(SRC_MODES)
  ) uDetect (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .trigVec(trigVec)
  );

  evmon_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .regAddr(regAddr),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .ctl    (ctl)
  );

  evmon_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrLo   (wrData[NUM_SRC-1:0]),
    .trigVec(trigVec),
    .enVec  (enVec),
    .pendVec(pendVec),
    .rdData (rdData),
    .evOut  (evOut)
  );

endmodule

// File: rtl/evmon_aggregator_chk.sv
module evmon_aggregator_chk
  import evmon_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               rdStb,
  input logic               wrStb,
  input logic [NUM_SRC-1:0] wrLo,
  input logic [DATA_W-1:0]  rdData,
  input logic               evOut,
  input logic [NUM_SRC-1:0] enVec,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] trigVec
);

  logic wrEn;
  logic wrPend;
  assign wrEn   = wrStb && (regAddr == ADDR_W'(EN_ADDR));
  assign wrPend = wrStb && (regAddr == ADDR_W'(PEND_ADDR));

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (enVec == $past(wrLo)));  // R1

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrPend |=> ((pendVec & $past(pendVec)) == $past(pendVec)));  // R3

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    wrPend |=> ((pendVec & $past(wrLo) & ~$past(trigVec)) == '0));  // R4

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrLo == '0)) |=> !evOut);  // R5

  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && (regAddr > ADDR_W'(PEND_ADDR))) |=> (rdData == '0));  // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData));  // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (trigVec != '0) |=> ((pendVec & $past(trigVec)) == $past(trigVec)));  // R10

endmodule

bind evmon_aggregator evmon_aggregator_chk #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .regAddr(regAddr),
  .rdStb  (rdStb),
  .wrStb  (wrStb),
  .wrLo   (wrData[NUM_SRC-1:0]),
  .rdData (rdData),
  .evOut  (evOut),
  .enVec  (enVec),
  .pendVec(pendVec),
  .trigVec(trigVec)
);

// File: tb/evmon_aggregator_test.sv
`timescale 1ns/1ps
module evmon_aggregator_test;

  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  // line0 level, line1 rise, line2 fall, line3 level
  localparam logic [7:0] MODES = 8'h24;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NUM_SRC-1:0] srcIn;
  logic [ADDR_W-1:0] regAddr;
  logic              rdStb;
  logic              wrStb;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;
  logic              evOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  evmon_aggregator #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SRC_MODES(MODES)
  ) uut (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .regAddr(regAddr),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .wrData (wrData),
    .rdData (rdData),
    .evOut  (evOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regAddr = ADDR_W'(a);
    wrData  = d;
    wrStb   = 1'b1;
    @(negedge clk);
    wrStb   = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    regAddr = ADDR_W'(a);
    rdStb   = 1'b1;
    @(negedge clk);
    rdStb   = 1'b0;
    d       = rdData;
  endtask

  task automatic setSrc(input logic [NUM_SRC-1:0] v);
    @(negedge clk);
    srcIn = v;
  endtask

  // leaves every pending bit set and all lines idle
  task automatic armAll();
    setSrc(4'b0100); idle(3);
    setSrc(4'b1011); idle(3);
    setSrc(4'b0000); idle(3);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rv;
    rstN = 1'b0; srcIn = '0; regAddr = '0; rdStb = 1'b0; wrStb = 1'b0; wrData = '0;
    idle(3);
    rstN = 1'b1;
    chk("R2 rdData after reset", 32'(rdData), 0);
    chk("R2 evOut after reset", 32'(evOut), 0);
    regRead(0, rv); chk("R2 enable after reset", 32'(rv), 0);
    regRead(1, rv); chk("R2 pending after reset", 32'(rv), 0);

    // R6 unmapped addresses and R1 upper bits dropped
    regRead(2, rv); chk("R6 addr2 reads 0", 32'(rv), 0);
    regRead(3, rv); chk("R6 addr3 reads 0", 32'(rv), 0);
    regWrite(0, 8'hFF);
    regRead(0, rv); chk("R1 enable keeps low bits", 32'(rv), 32'h0F);
    idle(2);
    chk("R6 rdData holds between reads", 32'(rdData), 32'h0F);
    regWrite(0, 8'h00);

    // R7 level line 0
    setSrc(4'b0001); idle(3);
    regRead(1, rv); chk("R7 level sets pending", 32'(rv), 32'h1);
    regWrite(1, 8'h01);
    regRead(1, rv); chk("R7 level re-sets while high", 32'(rv), 32'h1);
    setSrc(4'b0000); idle(3);
    regRead(1, rv); chk("R3 pending sticky after line low", 32'(rv), 32'h1);
    regWrite(1, 8'h01);
    regRead(1, rv); chk("R4 clear with line low", 32'(rv), 32'h0);

    // R8 rising line 1
    setSrc(4'b0010); idle(3);
    regRead(1, rv); chk("R8 rise sets pending", 32'(rv), 32'h2);
    regWrite(1, 8'h02);
    regRead(1, rv); chk("R8 no re-set while held high", 32'(rv), 32'h0);
    setSrc(4'b0000); idle(3);
    regRead(1, rv); chk("R8 fall does not set", 32'(rv), 32'h0);

    // R9 falling line 2
    setSrc(4'b0100); idle(3);
    regRead(1, rv); chk("R9 rise does not set", 32'(rv), 32'h0);
    setSrc(4'b0000); idle(3);
    regRead(1, rv); chk("R9 fall sets pending", 32'(rv), 32'h4);
    regWrite(1, 8'h04);
    regRead(1, rv); chk("R4 clear line 2", 32'(rv), 32'h0);

    // R10 clear lands in the cycle the rise detector fires
    setSrc(4'b0010);
    regWrite(1, 8'h02);
    regRead(1, rv); chk("R10 set wins over clear", 32'(rv), 32'h2);
    regWrite(1, 8'h02);
    regRead(1, rv); chk("R4 later clear works", 32'(rv), 32'h0);
    setSrc(4'b0000); idle(3);

    // R5 enable timing
    setSrc(4'b0010); idle(3); setSrc(4'b0000); idle(3);
    chk("R5 masked while enable 0", 32'(evOut), 0);
    regWrite(0, 8'h02);
    chk("R5 output high after enable write", 32'(evOut), 1);
    regWrite(0, 8'h0D);
    chk("R5 output low with other bits enabled", 32'(evOut), 0);

    // sweep all enable masks over full pending
    armAll();
    regRead(1, rv); chk("R3 all lines pending", 32'(rv), 32'hF);
    for (int e = 0; e < 16; e++) begin
      regWrite(0, 8'(e));
      chk("R5 sweep evOut", 32'(evOut), 32'(e != 0));
      regRead(0, rv); chk("R1 sweep enable readback", 32'(rv), 32'(e));
    end

    // sweep all clear masks, enable all
    regWrite(0, 8'h0F);
    for (int m = 0; m < 16; m++) begin
      armAll();
      regWrite(1, 8'(m));
      regRead(1, rv); chk("R4 sweep clear mask", 32'(rv), 32'((~m) & 4'hF));
      chk("R5 sweep evOut after clear", 32'(evOut), 32'(m != 15));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule